// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the hardware side of taking an interrupt on a 32-bit big-endian processor that keeps two supervisor stacks: a master stack and a separate interrupt stack. A 3-bit priority request and an 8-bit vector number arrive at the inputs. The block tests the request against the priority mask held in its status register. When it takes the request, it rewrites the status register and stores a four-halfword exception frame through a 16-bit write port, one halfword per cycle. It then presents the address of the vector-table slot that holds the handler pointer.

On an outermost entry, meaning the processor was in the master state, the frame goes to the master stack first and then again to the interrupt stack. The interrupt stack becomes active from then on. On a nested entry, the processor is already on the interrupt stack, so only one frame is stored there. The fetch of the handler itself, instruction decode and the return from the exception are handled elsewhere. The stack pointers and the status register start from parameter values at reset.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `sr_o` equals parameter `SR_RST` and `msp_o` and `isp_o` equal `MSP_RST` and `ISP_RST`. `busy_o`, `mem_we_o` and `fetch_valid_o` are low. `int_stack_o` is the inverse of status bit 12.
- R2: While idle, a request is taken at a clock edge only if `irq_lvl_i` is strictly greater than the mask in status bits 10:8. Level 7 is the highest priority. A level less than or equal to the mask causes no write, no change to the status register and no busy cycle.
- R3: When a request is taken, the status register changes in these bits and keeps all the others: the trace bits 15 and 14 are cleared, the supervisor bit 13 is set, the master bit 12 is cleared, and the mask in bits 10:8 takes the taken level.
- R4: A frame occupies eight bytes below the stack pointer, stored big-endian. The old status word is at offset 0, the upper PC half at 2, the lower PC half at 4 and the format/vector word at 6. The words are written from the highest address down, and the pointer is decremented by 2 before each write.
- R5: The format/vector word is the format parameter `FMT` in bits 15:12, zero in bits 11:10, and the vector number times 4 in bits 9:0.
- R6: On an outermost entry, where status bit 12 was set, the frame is written to the master stack and then to the interrupt stack. Each pointer drops by 8, and `int_stack_o` goes high.
- R7: On a nested entry, where status bit 12 was clear, a single frame is written to the interrupt stack, and `msp_o` does not change.
- R8: After the last frame word, `fetch_valid_o` pulses for one cycle with `fetch_addr_o` equal to `vbr_i` plus the vector number times 4.
- R9: `busy_o` is high from the cycle after acceptance through the fetch cycle. That is 9 cycles for an outermost entry and 5 for a nested one, with one write per cycle and no gaps. Requests presented while `busy_o` is high are not sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lvl_i | input | 3 | Requested priority level, 0 means no request |
| irq_vec_i | input | 8 | Vector number of the request |
| pc_i | input | 32 | Program counter to save in the frame |
| vbr_i | input | 32 | Vector table base address |
| busy_o | output | 1 | Entry sequence in progress |
| mem_we_o | output | 1 | Halfword write strobe |
| mem_addr_o | output | 32 | Byte address of the halfword written |
| mem_wdata_o | output | 16 | Halfword written |
| fetch_valid_o | output | 1 | One-cycle pulse, handler pointer address valid |
| fetch_addr_o | output | 32 | Address of the vector-table slot |
| sr_o | output | 16 | Current status register |
| msp_o | output | 32 | Master stack pointer |
| isp_o | output | 32 | Interrupt stack pointer |
| int_stack_o | output | 1 | Interrupt stack is the active stack |

## Verification
A wrong stack target or a wrong word counter shows up within the first write after acceptance, as an address that does not sit 2 below the previous one, or as a frame word out of order. A wrong outermost/nested decision shows up at the end of the sequence, as a wrong busy length of 9 versus 5 cycles and a master pointer that moved or failed to move. A mask compare that is off by one shows up at the next edge, as an entry where none was due or a missing one. A request that leaks in during busy shows up as a write nobody expected.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int SR_W      = 16;
  localparam int SR_T1     = 15;
  localparam int SR_T0     = 14;
  localparam int SR_S      = 13;
  localparam int SR_M      = 12;
  localparam int SR_IPL_LO = 8;
  localparam int IPL_W     = 3;
  localparam int VEC_W     = 8;
  localparam int HW_W      = 16;
  localparam int FRAME_WORDS = 4;
  localparam int STACKS    = 2;
  localparam int STK_MASTER = 0;
  localparam int STK_INT    = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_FETCH} seq_state_e;

  function automatic logic [HW_W-1:0] fvo_word(input logic [3:0] fmt, input logic [VEC_W-1:0] vec);
    return {fmt, 2'b00, vec, 2'b00};
  endfunction
endpackage

// File: rtl/irq_prio_gate.sv
module irq_prio_gate
  import irq_seq_pkg::*;
(
  input  logic              sample_i,
  input  logic [IPL_W-1:0]  lvl_i,
  input  logic [SR_W-1:0]   sr_i,
  output logic              take_o,
  output logic [SR_W-1:0]   sr_next_o
);
  logic [IPL_W-1:0] mask;

  assign mask   = sr_i[SR_IPL_LO +: IPL_W];
  assign take_o = sample_i && (lvl_i > mask);

  always_comb begin
    sr_next_o        = sr_i;
    sr_next_o[SR_T1] = 1'b0;
    sr_next_o[SR_T0] = 1'b0;
    sr_next_o[SR_S]  = 1'b1;
    sr_next_o[SR_M]  = 1'b0;
    sr_next_o[SR_IPL_LO +: IPL_W] = lvl_i;
  end
endmodule

// File: rtl/irq_frame_mux.sv
module irq_frame_mux
  import irq_seq_pkg::*;
#(
  parameter int          AW  = 32,
  parameter logic [3:0]  FMT = 4'h0,
  localparam int         IW  = $clog2(FRAME_WORDS)
) (
  input  logic [SR_W-1:0]  sr_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [IW-1:0]    idx_i,
  output logic [HW_W-1:0]  word_o
);
  // idx 0 goes to the highest address (offset 6), idx 3 to offset 0
  always_comb begin
    unique case (idx_i)
      2'd0:    word_o = fvo_word(FMT, vec_i);
      2'd1:    word_o = pc_i[HW_W-1:0];
      2'd2:    word_o = pc_i[AW-1 -: HW_W];
      default: word_o = sr_i;
    endcase
  end
endmodule

// File: rtl/irq_stack_regs.sv
module irq_stack_regs
  import irq_seq_pkg::*;
#(
  parameter int          AW      = 32,
  parameter logic [31:0] MSP_RST = 32'h0000_2000,
  parameter logic [31:0] ISP_RST = 32'h0000_1000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [STACKS-1:0]        dec_i,
  output logic [STACKS-1:0][AW-1:0] sp_o
);
  localparam logic [AW-1:0] STEP = AW'(HW_W / 8);

  for (genvar g = 0; g < STACKS; g++) begin : g_sp
    localparam logic [AW-1:0] RST_VAL = (g == STK_MASTER) ? AW'(MSP_RST) : AW'(ISP_RST);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sp_o[g] <= RST_VAL;
      else if (dec_i[g]) sp_o[g] <= sp_o[g] - STEP;
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          AW      = 32,
  parameter logic [15:0] SR_RST  = 16'hB01F,
  parameter logic [31:0] MSP_RST = 32'h0000_2000,
  parameter logic [31:0] ISP_RST = 32'h0000_1000,
  parameter logic [3:0]  FMT     = 4'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        irq_lvl_i,
  input  logic [7:0]        irq_vec_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [AW-1:0]     vbr_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  output logic              fetch_valid_o,
  output logic [AW-1:0]     fetch_addr_o,
  output logic [15:0]       sr_o,
  output logic [AW-1:0]     msp_o,
  output logic [AW-1:0]     isp_o,
  output logic              int_stack_o
);
  localparam int           IW   = $clog2(FRAME_WORDS);
  localparam logic [IW-1:0] LAST = IW'(FRAME_WORDS - 1);
  localparam logic [AW-1:0] STEP = AW'(HW_W / 8);

  seq_state_e              state_q;
  logic [IW-1:0]           idx_q;
  logic                    on_master_q;
  logic [SR_W-1:0]         sr_q, old_sr_q, sr_next;
  logic [AW-1:0]           pc_q;
  logic [VEC_W-1:0]        vec_q;
  logic                    take;
  logic [STACKS-1:0]       dec;
  logic [STACKS-1:0][AW-1:0] sp;
  logic [AW-1:0]           tgt_sp;
  logic [HW_W-1:0]         word;

  irq_prio_gate u_gate (
    .sample_i  (state_q == ST_IDLE),
    .lvl_i     (irq_lvl_i),
    .sr_i      (sr_q),
    .take_o    (take),
    .sr_next_o (sr_next)
  );

  irq_frame_mux #(.AW(AW), .FMT(FMT)) u_mux (
    .sr_i   (old_sr_q),
    .pc_i   (pc_q),
    .vec_i  (vec_q),
    .idx_i  (idx_q),
    .word_o (word)
  );

  irq_stack_regs #(.AW(AW), .MSP_RST(MSP_RST), .ISP_RST(ISP_RST)) u_stk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dec_i  (dec),
    .sp_o   (sp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      on_master_q <= 1'b0;
      sr_q        <= SR_RST;
      old_sr_q    <= '0;
      pc_q        <= '0;
      vec_q       <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take) begin
          old_sr_q    <= sr_q;
          sr_q        <= sr_next;
          pc_q        <= pc_i;
          vec_q       <= irq_vec_i;
          on_master_q <= sr_q[SR_M];
          idx_q       <= '0;
          state_q     <= ST_PUSH;
        end
        ST_PUSH: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST) begin
            if (on_master_q) on_master_q <= 1'b0;  // second copy on interrupt stack
            else             state_q     <= ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_we_o = (state_q == ST_PUSH);
  assign tgt_sp   = on_master_q ? sp[STK_MASTER] : sp[STK_INT];

  always_comb begin
    dec = '0;
    if (mem_we_o) dec[on_master_q ? STK_MASTER : STK_INT] = 1'b1;
  end

  assign mem_addr_o    = mem_we_o ? (tgt_sp - STEP) : '0;
  assign mem_wdata_o   = mem_we_o ? word : '0;
  assign busy_o        = (state_q != ST_IDLE);
  assign fetch_valid_o = (state_q == ST_FETCH);
  assign fetch_addr_o  = fetch_valid_o ? (vbr_i + {{(AW-VEC_W-2){1'b0}}, vec_q, 2'b00}) : '0;
  assign sr_o          = sr_q;
  assign msp_o         = sp[STK_MASTER];
  assign isp_o         = sp[STK_INT];
  assign int_stack_o   = ~sr_q[SR_M];
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    irq_lvl_i,
  input logic          busy_o,
  input logic          mem_we_o,
  input logic          fetch_valid_o,
  input logic [15:0]   sr_o,
  input logic          int_stack_o
);
  // R2
  ignore_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && irq_lvl_i <= sr_o[10:8]) |=> !busy_o);

  // R2
  take_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && irq_lvl_i > sr_o[10:8]) |=> busy_o);

  // R3
  sr_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (sr_o[13] && !sr_o[12] && sr_o[15:14] == 2'b00
                       && sr_o[10:8] == $past(irq_lvl_i)));

  // R6
  int_stack_on_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> int_stack_o);

  // R9
  write_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  // R9
  sr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(sr_o));

  // R8
  fetch_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |=> !busy_o);

  // R8
  fetch_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> $past(mem_we_o));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .irq_lvl_i     (irq_lvl_i),
  .busy_o        (busy_o),
  .mem_we_o      (mem_we_o),
  .fetch_valid_o (fetch_valid_o),
  .sr_o          (sr_o),
  .int_stack_o   (int_stack_o)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [15:0] SR0  = 16'hB01F;
  localparam logic [31:0] MSP0 = 32'h0000_2000;
  localparam logic [31:0] ISP0 = 32'h0000_1000;
  localparam logic [31:0] VBR  = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  irq_lvl_i = '0;
  logic [7:0]  irq_vec_i = '0;
  logic [31:0] pc_i = '0;
  logic [31:0] vbr_i = VBR;
  logic        busy_o, mem_we_o, fetch_valid_o, int_stack_o;
  logic [31:0] mem_addr_o, fetch_addr_o, msp_o, isp_o;
  logic [15:0] mem_wdata_o, sr_o;

  typedef struct packed { logic [31:0] a; logic [15:0] d; } wr_t;
  wr_t         wq[$];
  logic [31:0] fq[$];
  wr_t         e;
  logic [31:0] ef;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] m_sr = SR0;
  logic [31:0] m_msp = MSP0, m_isp = ISP0;

  always #2.5 clk = ~clk;

  irq_entry_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .irq_lvl_i(irq_lvl_i), .irq_vec_i(irq_vec_i),
    .pc_i(pc_i), .vbr_i(vbr_i), .busy_o(busy_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .fetch_valid_o(fetch_valid_o),
    .fetch_addr_o(fetch_addr_o), .sr_o(sr_o), .msp_o(msp_o), .isp_o(isp_o),
    .int_stack_o(int_stack_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // R4 R5: expected frame words, highest address first
  task automatic push_frame(input logic [31:0] sp, input logic [15:0] osr,
                            input logic [31:0] pc, input logic [7:0] vec);
    wq.push_back('{a: sp - 32'd2, d: {4'h0, 2'b00, vec, 2'b00}});
    wq.push_back('{a: sp - 32'd4, d: pc[15:0]});
    wq.push_back('{a: sp - 32'd6, d: pc[31:16]});
    wq.push_back('{a: sp - 32'd8, d: osr});
  endtask

  task automatic enter(input logic [2:0] lvl, input logic [7:0] vec, input logic [31:0] pc,
                       input bit disturb);
    bit take;
    bit outer;
    int exp_busy;
    int n;
    take  = lvl > m_sr[10:8];
    outer = m_sr[12];
    exp_busy = 0;
    if (take) begin
      if (outer) begin
        push_frame(m_msp, m_sr, pc, vec);   // R6 master copy first
        m_msp = m_msp - 32'd8;
      end
      push_frame(m_isp, m_sr, pc, vec);     // R7 interrupt stack copy
      m_isp = m_isp - 32'd8;
      fq.push_back(VBR + {22'd0, vec, 2'b00});
      m_sr = (m_sr & 16'h08FF) | 16'h2000 | {5'd0, lvl, 8'h00};
      exp_busy = outer ? 9 : 5;
    end
    @(negedge clk);
    irq_lvl_i = lvl; irq_vec_i = vec; pc_i = pc;
    @(negedge clk);
    n = 0;
    while (busy_o && n < 40) begin
      if (disturb) begin irq_lvl_i = 3'd7; irq_vec_i = 8'h77; end  // R9 not sampled
      n++;
      @(negedge clk);
    end
    irq_lvl_i = '0;
    @(negedge clk);
    chk(n == exp_busy, "R9 busy length", n, exp_busy);
    chk(sr_o == m_sr, take ? "R3 status after entry" : "R2 status unchanged", sr_o, m_sr);
    chk(msp_o == m_msp, outer ? "R6 master pointer" : "R7 master pointer held", msp_o, m_msp);
    chk(isp_o == m_isp, "R6 interrupt pointer", isp_o, m_isp);
    chk(int_stack_o == ~m_sr[12], "R6 active stack", int_stack_o, ~m_sr[12]);
    chk(wq.size() == 0, "R4 frame words outstanding", wq.size(), 0);
    chk(fq.size() == 0, "R8 fetch outstanding", fq.size(), 0);
  endtask

  // monitor: compare design output against queued expectations
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (mem_we_o) begin
        if (wq.size() == 0) chk(1'b0, "R2 unexpected write", mem_addr_o, 0);
        else begin
          e = wq.pop_front();
          chk(mem_addr_o == e.a, "R4 write address", mem_addr_o, e.a);
          chk(mem_wdata_o == e.d, "R5 write data", {16'd0, mem_wdata_o}, {16'd0, e.d});
        end
      end
      if (fetch_valid_o) begin
        if (fq.size() == 0) chk(1'b0, "R8 unexpected fetch", fetch_addr_o, 0);
        else begin
          ef = fq.pop_front();
          chk(fetch_addr_o == ef, "R8 fetch address", fetch_addr_o, ef);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    chk(1'b0, "R9 watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk(sr_o == SR0, "R1 reset status", sr_o, SR0);
    chk(msp_o == MSP0, "R1 reset master pointer", msp_o, MSP0);
    chk(isp_o == ISP0, "R1 reset interrupt pointer", isp_o, ISP0);
    chk(!busy_o && !mem_we_o && !fetch_valid_o, "R1 idle outputs",
        {busy_o, mem_we_o, fetch_valid_o}, 0);
    chk(int_stack_o == 1'b0, "R1 master stack active", int_stack_o, 0);

    enter(3'd0, 8'h10, 32'h0000_0100, 1'b0);   // R2 level 0 at mask 0
    enter(3'd3, 8'h40, 32'h1234_5678, 1'b1);   // R6 outermost, disturbed while busy
    enter(3'd2, 8'h21, 32'h0000_0200, 1'b0);   // R2 below mask
    enter(3'd3, 8'h22, 32'h0000_0300, 1'b0);   // R2 equal to mask
    enter(3'd5, 8'h19, 32'hCAFE_0010, 1'b0);   // R7 nested
    enter(3'd7, 8'hFF, 32'h0000_FFFE, 1'b0);   // R5 top vector, R7 nested again
    enter(3'd7, 8'h01, 32'h0000_0400, 1'b0);   // R2 level 7 at mask 7

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule